// File: doc/BRIEF.md
# Decimal Program-Flow Control Unit

This unit carries out the program-control group of a decimal-digit machine whose words are six BCD digits and whose addresses are three BCD digits. It is given an instruction that has already been decoded: the three leading opcode digits, a register number digit and a three-digit target address. It also receives the N, Z, V and C condition flags, the address of the next sequential instruction, and the current contents of the named register. From these it decides where execution continues. It resolves seven conditional and unconditional branches, it halts, it switches the trace flag, and it runs subroutine calls and returns.

A call does not push the return address. It saves the old contents of a chosen linkage register on a hardware stack, which lives in the lowest stack-sized region of data memory. It then puts the return address into that register and jumps. A return jumps to the address held in the linkage register and restores the register from the stack. The stack memory is outside the unit, and it has one cycle of read latency. For that reason the restore write-back of a return arrives one cycle after the return, and `busy` is high during that cycle. A push past the top of the stack, or a pop from an empty stack, raises a sticky fault and stops the machine.

Top module: `flow_ctl`

## Requirements
- R1: After reset, `halted`, `trace_on`, `stack_fault`, `busy`, `pc_load`, `reg_we`, `stk_we` and `stk_re` are all 0, and the stack is empty, so the first push writes stack word 99.
- R2: Opcodes are BCD digit triples. 180 is an unconditional branch, and 181 to 186 are conditional branches. A taken branch drives `pc_load`=1 and `next_pc`=`target` in the same cycle. A branch that is not taken drives `pc_load`=0 and `next_pc`=`pc_in`.
- R3: Opcode 181 is taken when Z=1. Opcode 186 is taken when Z=0.
- R4: Opcode 182 is taken when N differs from V. Opcode 185 is taken when N equals V.
- R5: Opcode 183 is taken when Z=1 or N differs from V. Opcode 184 is taken when Z=0 and N equals V.
- R6: The C flag has no effect on any branch decision.
- R7: A call (opcode 060) acts in the same cycle. It drives `stk_we`=1, with `stk_wdata`=`link_rdata` at stack word 99 minus the current depth. It drives `reg_we`=1 to register `reg_num`, with data 000 followed by `pc_in`. It drives `pc_load`=1 and `next_pc`=`target`.
- R8: A return (opcode 070) drives `pc_load`=1, with `next_pc` set to the low three digits of `link_rdata`. In the same cycle it drives `stk_re`=1 at the word written by the most recent unmatched push. In the next cycle it drives `busy`=1 and `reg_we`=1, writing `stk_rdata` to the same register number.
- R9: The stack is last-in first-out. Successive pushes use words 99, 98, 97 and so on, and pops read them back in reverse order.
- R10: The stack holds 100 entries. A call made when 100 entries are held, or a return made when none are held, performs no stack access, no register write and no jump. From the next cycle it sets `stack_fault` and `halted`, and both stay set.
- R11: Opcode 000 sets `halted` from the next cycle and does not jump. While `halted` is 1, instructions cause no jump, no stack access and no register write.
- R12: Opcode 191 sets `trace_on` and opcode 190 clears it, from the next cycle. Opcode 192 changes nothing.
- R13: An opcode outside the set above, for example 020, causes no jump, no stack access, no register write and no change of state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_valid | input | 1 | A decoded instruction is presented this cycle |
| op_code | input | 12 | Three leading opcode digits, BCD |
| reg_num | input | 4 | Linkage register number digit, BCD |
| target | input | 12 | Three-digit target address, BCD |
| pc_in | input | 12 | Address of the next sequential instruction, BCD |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag (not used by any decision) |
| link_rdata | input | 24 | Current contents of register `reg_num`, six BCD digits |
| stk_rdata | input | 24 | Stack memory read data, valid one cycle after `stk_re` |
| next_pc | output | 12 | Address where execution continues |
| pc_load | output | 1 | `next_pc` replaces the sequential address |
| reg_we | output | 1 | Register write-back enable |
| reg_wnum | output | 4 | Register number for the write-back |
| reg_wdata | output | 24 | Register write-back data |
| stk_we | output | 1 | Stack memory write |
| stk_re | output | 1 | Stack memory read |
| stk_addr | output | 7 | Stack word address, 0 to 99, binary |
| stk_wdata | output | 24 | Stack memory write data |
| halted | output | 1 | Execution stopped (sticky until reset) |
| trace_on | output | 1 | Trace flag |
| stack_fault | output | 1 | Sticky stack overflow or underflow |
| busy | output | 1 | Return write-back cycle; no instruction accepted |

## Verification
The bench runs every branch opcode against all sixteen flag patterns and compares the result with a signed-compare reading of the flags. A design that tested N alone, rather than N against V, would take the wrong path when overflow is set, and a design that used C would change its decision when only C changes. Nested calls and returns check that the stack grows downward from word 99 and unwinds in the opposite order. An off-by-one in the pre-decrement or post-increment would read back a neighbouring word and restore the wrong value. The bench fills the stack to exactly 100 entries, then makes one more call, and it also makes a return on an empty stack. A design with a wrong bound would either lose an entry or write below word 0 instead of faulting. A final group checks that halt is sticky and that instructions are ignored after it.

// File: rtl/flow_pkg.sv
package flow_pkg;

  // Opcode digit triples, BCD-coded in hex literals
  localparam logic [11:0] OPC_HALT = 12'h000;
  localparam logic [11:0] OPC_CALL = 12'h060;
  localparam logic [11:0] OPC_RET  = 12'h070;
  localparam logic [7:0]  OPC_BRHI = 8'h18;   // 180..186 share these digits
  localparam logic [11:0] OPC_TOFF = 12'h190;
  localparam logic [11:0] OPC_TON  = 12'h191;
  localparam logic [11:0] OPC_NOP  = 12'h192;

  typedef enum logic [2:0] {
    K_NONE, K_HALT, K_CALL, K_RET, K_BRANCH, K_TOFF, K_TON, K_NOP
  } op_kind_e;

  // Branch condition by selector digit 0..6 (always, eq, lt, le, gt, ge, ne)
  function automatic logic cond_met(input logic [2:0] sel,
                                    input logic n, input logic z, input logic v);
    logic lt;
    lt = n ^ v;
    case (sel)
      3'd0:    cond_met = 1'b1;
      3'd1:    cond_met = z;
      3'd2:    cond_met = lt;
      3'd3:    cond_met = z | lt;
      3'd4:    cond_met = ~z & ~lt;
      3'd5:    cond_met = ~lt;
      3'd6:    cond_met = ~z;
      default: cond_met = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
(
  input  logic [11:0] opc,
  output op_kind_e    kind,
  output logic [2:0]  cond_sel
);
  logic br_hit;
  assign br_hit   = (opc[11:4] == OPC_BRHI) && (opc[3:0] <= 4'd6);
  assign cond_sel = opc[2:0];

  always_comb begin
    kind = K_NONE;
    if (br_hit)                kind = K_BRANCH;
    else if (opc == OPC_HALT)  kind = K_HALT;
    else if (opc == OPC_CALL)  kind = K_CALL;
    else if (opc == OPC_RET)   kind = K_RET;
    else if (opc == OPC_TOFF)  kind = K_TOFF;
    else if (opc == OPC_TON)   kind = K_TON;
    else if (opc == OPC_NOP)   kind = K_NOP;
  end
endmodule

// File: rtl/flow_cond.sv
module flow_cond
  import flow_pkg::*;
(
  input  logic       is_branch,
  input  logic [2:0] cond_sel,
  input  logic       n,
  input  logic       z,
  input  logic       v,
  output logic       taken
);
  assign taken = is_branch & cond_met(cond_sel, n, z, v);
endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int DEPTH = 100,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] addr,
  output logic          fault_evt
);
  logic [CW-1:0] used;
  logic full, empty;

  assign full      = (int'(used) == DEPTH);
  assign empty     = (used == '0);
  assign push_ok   = push_req & ~full;
  assign pop_ok    = pop_req & ~empty;
  assign fault_evt = (push_req & full) | (pop_req & empty);

  // push writes at top-minus-depth; pop reads the word just above that
  assign addr = pop_req ? AW'(DEPTH - int'(used))
                        : AW'(DEPTH - 1 - int'(used));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       used <= '0;
    else if (push_ok) used <= used + 1'b1;
    else if (pop_ok)  used <= used - 1'b1;
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used) <= DEPTH); // R10
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (used == $past(used) + 1'b1)); // R9
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (used == $past(used) - 1'b1)); // R9
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> !(push_ok || pop_ok)); // R10
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import flow_pkg::*;
#(
  parameter int ADDR_DIGITS = 3,
  parameter int WORD_DIGITS = 6,
  parameter int STACK_WORDS = 100,
  localparam int ADDR_W = 4 * ADDR_DIGITS,
  localparam int WORD_W = 4 * WORD_DIGITS,
  localparam int STK_AW = $clog2(STACK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_valid,
  input  logic [11:0]       op_code,
  input  logic [3:0]        reg_num,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [WORD_W-1:0] link_rdata,
  input  logic [WORD_W-1:0] stk_rdata,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pc_load,
  output logic              reg_we,
  output logic [3:0]        reg_wnum,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              stk_we,
  output logic              stk_re,
  output logic [STK_AW-1:0] stk_addr,
  output logic [WORD_W-1:0] stk_wdata,
  output logic              halted,
  output logic              trace_on,
  output logic              stack_fault,
  output logic              busy
);
  op_kind_e   kind;
  logic [2:0] cond_sel;
  logic       exec, br_taken, push_ok, pop_ok, fault_evt;
  logic       do_halt, do_call, do_ret, do_br;
  logic [3:0] pend_num;
  logic       unused_bits;

  assign unused_bits = flag_c;

  flow_decode u_dec (.opc(op_code), .kind(kind), .cond_sel(cond_sel));

  assign exec    = exec_valid & ~halted & ~busy;
  assign do_halt = exec & (kind == K_HALT);
  assign do_call = exec & (kind == K_CALL);
  assign do_ret  = exec & (kind == K_RET);
  assign do_br   = exec & (kind == K_BRANCH);

  flow_cond u_cond (
    .is_branch(do_br), .cond_sel(cond_sel),
    .n(flag_n), .z(flag_z), .v(flag_v), .taken(br_taken)
  );

  flow_stack #(.DEPTH(STACK_WORDS)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_req(do_call), .pop_req(do_ret),
    .push_ok(push_ok), .pop_ok(pop_ok), .addr(stk_addr), .fault_evt(fault_evt)
  );

  assign pc_load   = br_taken | push_ok | pop_ok;
  assign next_pc   = pop_ok ? link_rdata[ADDR_W-1:0]
                   : (push_ok | br_taken) ? target : pc_in;
  assign stk_we    = push_ok;
  assign stk_re    = pop_ok;
  assign stk_wdata = link_rdata;
  assign reg_we    = push_ok | busy;
  assign reg_wnum  = busy ? pend_num : reg_num;
  assign reg_wdata = busy ? stk_rdata : {{(WORD_W-ADDR_W){1'b0}}, pc_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted      <= 1'b0;
      stack_fault <= 1'b0;
      trace_on    <= 1'b0;
      busy        <= 1'b0;
      pend_num    <= '0;
    end else begin
      halted      <= halted | do_halt | fault_evt;
      stack_fault <= stack_fault | fault_evt;
      busy        <= pop_ok;
      if (pop_ok) pend_num <= reg_num;
      if (exec && kind == K_TON)  trace_on <= 1'b1;
      if (exec && kind == K_TOFF) trace_on <= 1'b0;
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R11
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(pc_load || stk_we || stk_re)); // R11
  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> halted); // R10
  AST_STK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re)); // R9
  AST_RET_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re |=> (reg_we && busy && reg_wnum == $past(reg_num))); // R8
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R8
  AST_STK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we || stk_re) |-> (int'(stk_addr) < STACK_WORDS)); // R10
endmodule

// File: tb/sim_flow_ctl.sv
module sim_flow_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_valid = 1'b0;
  logic [11:0] op_code = '0;
  logic [3:0]  reg_num = '0;
  logic [11:0] target = '0;
  logic [11:0] pc_in = '0;
  logic        flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
  logic [23:0] link_rdata = '0;
  logic [23:0] stk_rdata;
  logic [11:0] next_pc;
  logic        pc_load, reg_we, stk_we, stk_re, halted, trace_on, stack_fault, busy;
  logic [3:0]  reg_wnum;
  logic [23:0] reg_wdata, stk_wdata;
  logic [6:0]  stk_addr;

  int checks = 0;
  int errors = 0;
  logic [23:0] smem [0:99];

  always #5 clk = ~clk;

  flow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .op_code(op_code),
    .reg_num(reg_num), .target(target), .pc_in(pc_in), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .link_rdata(link_rdata),
    .stk_rdata(stk_rdata), .next_pc(next_pc), .pc_load(pc_load), .reg_we(reg_we),
    .reg_wnum(reg_wnum), .reg_wdata(reg_wdata), .stk_we(stk_we), .stk_re(stk_re),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .halted(halted),
    .trace_on(trace_on), .stack_fault(stack_fault), .busy(busy)
  );

  // stack memory model with one cycle of read latency
  always @(posedge clk) begin
    if (stk_we) smem[stk_addr] <= stk_wdata;
    if (stk_re) stk_rdata <= smem[stk_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] op, input logic [3:0] rn,
                       input logic [11:0] tg, input logic [11:0] pc,
                       input logic [23:0] lk);
    @(negedge clk);
    exec_valid = 1'b1; op_code = op; reg_num = rn; target = tg;
    pc_in = pc; link_rdata = lk;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    exec_valid = 1'b0;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; exec_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
  endtask

  function automatic logic expect_taken(input int sel, input logic n, input logic z, input logic v);
    logic less;
    less = (n != v);   // signed result below zero, overflow corrected
    case (sel)
      0: return 1'b1;
      1: return z;
      2: return less;
      3: return less || z;
      4: return !less && !z;
      5: return !less;
      default: return !z;
    endcase
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 halted", halted, 0);
    check("R1 trace_on", trace_on, 0);
    check("R1 stack_fault", stack_fault, 0);
    check("R1 busy", busy, 0);
    check("R1 pc_load", pc_load, 0);
    check("R1 writes", {reg_we, stk_we, stk_re}, 0);
    apply(12'h060, 4'd1, 12'h300, 12'h101, 24'h000042);
    check("R1 first push addr", stk_addr, 99);
    idle();
  endtask

  task automatic t_branches();
    do_reset();
    for (int sel = 0; sel < 7; sel++) begin
      for (int f = 0; f < 8; f++) begin
        logic e, r0;
        {flag_n, flag_z, flag_v} = 3'(f);
        e = expect_taken(sel, flag_n, flag_z, flag_v);
        flag_c = 1'b0;
        apply(12'h180 + 12'(sel), 4'd0, 12'h777, 12'h123, '0);
        r0 = pc_load;
        check($sformatf("R2 R3 R4 R5 op18%0d nzv=%0d load", sel, f), pc_load, e);
        check($sformatf("R2 op18%0d nzv=%0d next_pc", sel, f), next_pc, e ? 12'h777 : 12'h123);
        flag_c = 1'b1;
        #1;
        check($sformatf("R6 op18%0d nzv=%0d carry", sel, f), pc_load, r0);
      end
    end
    flag_c = 1'b0;
    idle();
    check("R2 branch no writes", {reg_we, stk_we, stk_re}, 0);
  endtask

  task automatic t_call_return();
    do_reset();
    apply(12'h060, 4'd3, 12'h400, 12'h205, 24'h000123);
    check("R7 call stk_we", stk_we, 1);
    check("R7 call addr", stk_addr, 99);
    check("R7 call wdata", stk_wdata, 24'h000123);
    check("R7 call reg_we", reg_we, 1);
    check("R7 call wnum", reg_wnum, 3);
    check("R7 call reg data", reg_wdata, 24'h000205);
    check("R7 call jump", {pc_load, next_pc}, {1'b1, 12'h400});
    apply(12'h060, 4'd3, 12'h500, 12'h402, 24'h000205);
    check("R9 nested push addr", stk_addr, 98);
    apply(12'h070, 4'd3, 12'h000, 12'h501, 24'h000402);
    check("R8 ret jump", {pc_load, next_pc}, {1'b1, 12'h402});
    check("R8 ret read", {stk_re, stk_we}, 2'b10);
    check("R9 ret addr", stk_addr, 98);
    idle();
    check("R8 busy", busy, 1);
    check("R8 restore we", reg_we, 1);
    check("R8 restore wnum", reg_wnum, 3);
    check("R9 restore data", reg_wdata, 24'h000205);
    apply(12'h070, 4'd3, 12'h000, 12'h403, 24'h000205);
    check("R8 ret2 jump", next_pc, 12'h205);
    check("R9 ret2 addr", stk_addr, 99);
    idle();
    check("R9 restore2 data", reg_wdata, 24'h000123);
    idle();
    check("R8 busy clears", busy, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 100; i++) begin
      apply(12'h060, 4'd2, 12'h600, 12'h100, 24'(i));
      if (stk_addr != 7'(99 - i) || !stk_we) check("R10 fill addr", {stk_we, stk_addr}, {1'b1, 7'(99 - i)});
    end
    check("R10 last slot", stk_addr, 0);
    apply(12'h060, 4'd2, 12'h600, 12'h100, 24'h999);
    check("R10 overflow no access", {stk_we, reg_we, pc_load}, 0);
    idle();
    check("R10 overflow fault", {stack_fault, halted}, 2'b11);
  endtask

  task automatic t_underflow();
    do_reset();
    apply(12'h070, 4'd4, 12'h000, 12'h150, 24'h000321);
    check("R10 underflow no access", {stk_re, reg_we, pc_load}, 0);
    idle();
    check("R10 underflow fault", {stack_fault, halted}, 2'b11);
    idle();
    check("R10 fault sticky", stack_fault, 1);
  endtask

  task automatic t_halt();
    do_reset();
    apply(12'h000, 4'd0, 12'h000, 12'h110, '0);
    check("R11 halt no jump", pc_load, 0);
    idle();
    check("R11 halted", {halted, stack_fault}, 2'b10);
    apply(12'h180, 4'd0, 12'h444, 12'h111, '0);
    check("R11 branch ignored", pc_load, 0);
    apply(12'h060, 4'd1, 12'h444, 12'h111, '0);
    check("R11 call ignored", {stk_we, reg_we, pc_load}, 0);
    apply(12'h191, 4'd0, 12'h000, 12'h111, '0);
    idle();
    check("R11 trace ignored", trace_on, 0);
  endtask

  task automatic t_trace_misc();
    do_reset();
    apply(12'h191, 4'd0, 12'h000, 12'h100, '0);
    idle();
    check("R12 ton", trace_on, 1);
    apply(12'h192, 4'd0, 12'h333, 12'h101, '0);
    check("R12 nop no jump", pc_load, 0);
    idle();
    check("R12 nop keeps", trace_on, 1);
    apply(12'h190, 4'd0, 12'h000, 12'h102, '0);
    idle();
    check("R12 toff", trace_on, 0);
    apply(12'h020, 4'd5, 12'h333, 12'h103, 24'h000777);
    check("R13 other op quiet", {pc_load, reg_we, stk_we, stk_re}, 0);
    check("R13 next_pc seq", next_pc, 12'h103);
    apply(12'h187, 4'd5, 12'h333, 12'h104, '0);
    check("R13 op187 quiet", pc_load, 0);
    idle();
    check("R13 state kept", {halted, trace_on, stack_fault, busy}, 0);
    apply(12'h060, 4'd1, 12'h300, 12'h105, 24'h1);
    check("R13 stack untouched", stk_addr, 99);
    idle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_branches();
    t_call_return();
    t_overflow();
    t_underflow();
    t_halt();
    t_trace_misc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule